// File: doc/BRIEF.md
# Split Serial Output Register Sequencer

This block holds a 256-word by 16-bit serial output register and the pointer that walks through it. A wide load port accepts one half row (256 words) already chosen by the surrounding memory array model. A full load copies every word and places the pointer at any tap. A split load refills only the half that is not being read, so a display stream can run without pause while the idle half takes the next line of data.

The pointer moves one position on each cycle where the serial step strobe is high. That strobe is the synchronised rising edge of the serial clock. When the pointer leaves the last word of a half and a split load is waiting, it goes straight to the other half at the stored start position. With nothing waiting, it counts on in sequence. A status output shows which half the pointer is in.

An active-low output enable drives both the data outputs and the status output, and floats them when it is released. A split tap that points at the last word of a half is not valid. The block replaces it with position 0 and raises an error pulse.

Top module: `split_serial_seq`

## Requirements
- R1: After reset the pointer is at word 0, the status output is low, `tap_err_o` is low, and every word holds 0. With the enable asserted, `sq_o` reads 0.
- R2: A full load (`load_full_i`) copies all 256 words of `row_i` into the register, with word i at bits [16i+15:16i]. The pointer takes the value of the 8-bit `tap_i`, and from the next cycle `sq_o` shows word `tap_i`.
- R3: A split load (`load_split_i`) ignores `tap_i[7]`. It writes only the half that the pointer does not occupy after this cycle's step. Words 0–127 of `row_i` go into the low half and words 128–255 go into the high half. The occupied half is left unchanged.
- R4: With no split load waiting, a step moves the pointer to the next word, and the pointer wraps from 255 to 0. A step from 127 goes to 128.
- R5: With a split load waiting, a step from the last word of the current half (position 127 or 255) moves the pointer into the other half at the stored start position `tap_i[6:0]`. The crossing clears the waiting load, so the next crossing is sequential unless a new split load arrives first.
- R6: Without a step or a full load, the pointer holds. Steps advance the pointer whether or not the outputs are enabled.
- R7: While `oe_n_i` is high, `sq_o` and `half_o` are high-impedance. While it is low, they show the addressed word and the status.
- R8: A split load whose `tap_i[6:0]` is 127 stores start position 0 instead, and `tap_err_o` is high for exactly the following cycle.
- R9: `half_o` is low while the pointer is in words 0–127 and high while it is in words 128–255. It changes on a crossing, and after a full load it follows `tap_i[7]`.
- R10: A full load takes priority. In the same cycle it cancels any split load and any step, and it clears a waiting split load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One pulse per serial clock rising edge; advances the pointer |
| oe_n_i | input | 1 | Active-low output enable for `sq_o` and `half_o` |
| load_full_i | input | 1 | Full load strobe |
| load_split_i | input | 1 | Split load strobe |
| tap_i | input | 8 | Start position for either load |
| row_i | input | 4096 | Half-row data, word i at bits [16i+15:16i] |
| sq_o | output | 16 | Serial data word at the pointer, tri-stated |
| half_o | output | 1 | Active-half status, tri-stated |
| tap_err_o | output | 1 | One-cycle pulse after a split load with an invalid tap |

## Verification
The assertions take for granted that every strobe is a clean, known value sampled at the rising clock edge. They also treat `step_i` as already synchronised to the clock, one pulse per serial edge. The stimulus changes every input only on the falling edge, so each value is stable across the rising edge that samples it. The random section lets steps, split loads and full loads land in the same cycle and taps fall on the invalid positions, all within that rule. This tests the priority and the step-then-load ordering without breaking the synchronous input assumption.

// File: rtl/split_serial_pkg.sv
package split_serial_pkg;

    localparam int DEF_DEPTH = 256;
    localparam int DEF_WIDTH = 16;

    // which words the storage writes this cycle
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_LOW  = 2'd1,
        LD_HIGH = 2'd2,
        LD_ALL  = 2'd3
    } load_e;

endpackage

// File: rtl/split_serial_store.sv
module split_serial_store
    import split_serial_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  load_e                  ld_i,
    input  logic [DEPTH*WIDTH-1:0] row_i,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [WIDTH-1:0]       rd_data_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [DEPTH-1:0] we;

    for (genvar i = 0; i < DEPTH; i++) begin : g_we
        if (i < HALF) begin : g_low
            assign we[i] = (ld_i == LD_ALL) || (ld_i == LD_LOW);
        end else begin : g_high
            assign we[i] = (ld_i == LD_ALL) || (ld_i == LD_HIGH);
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = we[i] ? row_i[i*WIDTH +: WIDTH] : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/split_serial_ptr.sv
module split_serial_ptr
    import split_serial_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          load_full_i,
    input  logic          load_split_i,
    input  logic [AW-1:0] tap_i,
    output logic [AW-1:0] ptr_o,
    output load_e         ld_o,
    output logic          err_o
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          pend;
        logic [AW-2:0] tap;
        logic          err;
    } state_t;

    state_t        st_q, st_d;
    logic [AW-1:0] step_ptr;
    logic          at_last;
    logic          bad_tap;

    assign at_last = &st_q.ptr[AW-2:0];
    assign bad_tap = &tap_i[AW-2:0];

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        ld_o     = LD_NONE;
        step_ptr = st_q.ptr;
        if (load_full_i) begin
            st_d.ptr  = tap_i;
            st_d.pend = 1'b0;
            ld_o      = LD_ALL;
        end else begin
            if (step_i) begin
                if (at_last && st_q.pend) begin
                    step_ptr  = {~st_q.ptr[AW-1], st_q.tap};
                    st_d.pend = 1'b0;
                end else begin
                    step_ptr = st_q.ptr + 1'b1;
                end
            end
            if (load_split_i) begin
                // refill the half the pointer is not in after this step
                ld_o      = step_ptr[AW-1] ? LD_LOW : LD_HIGH;
                st_d.pend = 1'b1;
                st_d.tap  = bad_tap ? '0 : tap_i[AW-2:0];
                st_d.err  = bad_tap;
            end
            st_d.ptr = step_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
    assign err_o = st_q.err;

    a_r6_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_full_i) |=> (st_q.ptr == $past(st_q.ptr)));

    a_r4_sequential_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_full_i && !st_q.pend) |=> (st_q.ptr == AW'($past(st_q.ptr) + 1'b1)));

    a_r5_crossing_changes_half: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_full_i && st_q.pend && at_last)
        |=> (st_q.ptr[AW-1] != $past(st_q.ptr[AW-1])));

    a_r8_error_means_zero_tap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (st_q.pend && st_q.tap == '0));

    a_r10_full_sets_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        load_full_i |=> (st_q.ptr == $past(tap_i) && !st_q.pend));

endmodule

// File: rtl/split_serial_seq.sv
module split_serial_seq
    import split_serial_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_i,
    input  logic                   oe_n_i,
    input  logic                   load_full_i,
    input  logic                   load_split_i,
    input  logic [AW-1:0]          tap_i,
    input  logic [DEPTH*WIDTH-1:0] row_i,
    output logic [WIDTH-1:0]       sq_o,
    output logic                   half_o,
    output logic                   tap_err_o
);

    logic [AW-1:0]    ptr;
    load_e            ld;
    logic [WIDTH-1:0] rd_data;

    split_serial_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step_i),
        .load_full_i  (load_full_i),
        .load_split_i (load_split_i),
        .tap_i        (tap_i),
        .ptr_o        (ptr),
        .ld_o         (ld),
        .err_o        (tap_err_o)
    );

    split_serial_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld),
        .row_i     (row_i),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data)
    );

    assign sq_o   = oe_n_i ? {WIDTH{1'bz}} : rd_data;
    assign half_o = oe_n_i ? 1'bz : ptr[AW-1];

    a_r3_split_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        (load_split_i && !load_full_i) |-> (ld == LD_LOW || ld == LD_HIGH));

endmodule

// File: tb/split_serial_seq_tb.sv
`timescale 1ns/1ps
module split_serial_seq_tb;

    localparam int DEPTH = 256;
    localparam int W     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0, oe_n = 1'b0, ld_full = 1'b0, ld_split = 1'b0;
    logic [7:0] tap = '0;
    logic [DEPTH*W-1:0] row = '0;
    logic [W-1:0] sq;
    logic half, terr;

    int n_run = 0, n_fail = 0;

    logic [W-1:0] ref_mem [DEPTH];
    logic [7:0]   ref_ptr;
    logic         ref_pend;
    logic [6:0]   ref_tap;
    logic         ref_err;

    always #2 clk = ~clk;

    split_serial_seq u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step), .oe_n_i(oe_n),
        .load_full_i(ld_full), .load_split_i(ld_split), .tap_i(tap),
        .row_i(row), .sq_o(sq), .half_o(half), .tap_err_o(terr)
    );

    task automatic new_row();
        for (int i = 0; i < DEPTH; i++) row[i*W +: W] = W'($urandom);
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        logic [W-1:0] e_sq;
        logic         e_half;
        e_sq   = oe_n ? {W{1'bz}} : ref_mem[ref_ptr];
        e_half = oe_n ? 1'bz : ref_ptr[7];
        chk({req, " sq"}, sq, e_sq);
        chk({req, " half"}, {15'd0, half}, {15'd0, e_half});
        chk({req, " err"}, {15'd0, terr}, {15'd0, ref_err});
    endtask

    // one clock: inputs set now (falling edge), model updated at rising edge
    task automatic cyc(string req, logic s, logic f, logic sp, logic [7:0] t);
        logic [7:0] np;
        step = s; ld_full = f; ld_split = sp; tap = t;
        @(posedge clk);
        ref_err = 1'b0;
        if (f) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = row[i*W +: W];
            ref_ptr  = t;
            ref_pend = 1'b0;
        end else begin
            np = ref_ptr;
            if (s) begin
                if (ref_ptr[6:0] == 7'd127 && ref_pend) begin
                    np = {~ref_ptr[7], ref_tap};
                    ref_pend = 1'b0;
                end else begin
                    np = ref_ptr + 8'd1;
                end
            end
            if (sp) begin
                for (int i = 0; i < 128; i++) begin
                    if (np[7]) ref_mem[i] = row[i*W +: W];
                    else       ref_mem[i+128] = row[(i+128)*W +: W];
                end
                ref_pend = 1'b1;
                if (t[6:0] == 7'd127) begin
                    ref_tap = 7'd0;
                    ref_err = 1'b1;
                end else begin
                    ref_tap = t[6:0];
                end
            end
            ref_ptr = np;
        end
        @(negedge clk);
        check_outs(req);
    endtask

    task automatic steps(string req, int n);
        for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, 1'b0, 8'd0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_ptr = '0; ref_pend = 1'b0; ref_tap = '0; ref_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1 reset");

        // R7: floating outputs; R6: steps still count while disabled
        oe_n = 1'b1;
        cyc("R7 hiz", 1'b0, 1'b0, 1'b0, 8'd0);
        steps("R6 step while disabled", 3);
        oe_n = 1'b0;
        cyc("R6 hold", 1'b0, 1'b0, 1'b0, 8'd0);
        cyc("R6 hold", 1'b0, 1'b0, 1'b0, 8'd0);

        // R2 full load at tap 250, R4 wrap 255 to 0, R9 status follows
        new_row();
        cyc("R2 full load", 1'b0, 1'b1, 1'b0, 8'd250);
        chk("R9 half after full load", {15'd0, half}, 16'd1);
        steps("R4 wrap 255->0", 7);
        chk("R9 half after wrap", {15'd0, half}, 16'd0);

        // R4 sequential 127->128
        new_row();
        cyc("R2 full load", 1'b0, 1'b1, 1'b0, 8'd120);
        steps("R4 127->128", 10);

        // R3 split while in high half, bit 7 of tap ignored (0x85 -> 5)
        new_row();
        cyc("R3 split load", 1'b1, 1'b0, 1'b1, 8'h85);
        steps("R3 active half untouched", 20);
        while (ref_ptr != 8'd255) cyc("R3 read high", 1'b1, 1'b0, 1'b0, 8'd0);
        cyc("R5 jump to tap", 1'b1, 1'b0, 1'b0, 8'd0);
        chk("R5 pointer at stored tap", sq, ref_mem[5]);
        chk("R9 half after crossing", {15'd0, half}, 16'd0);

        // R8 invalid tap 127 in split
        new_row();
        cyc("R8 invalid tap", 1'b0, 1'b0, 1'b1, 8'd127);
        chk("R8 error pulse", {15'd0, terr}, 16'd1);
        cyc("R8 error clears", 1'b1, 1'b0, 1'b0, 8'd0);
        while (ref_ptr != 8'd127) cyc("R8 read low", 1'b1, 1'b0, 1'b0, 8'd0);
        cyc("R8 jump to position 0", 1'b1, 1'b0, 1'b0, 8'd0);
        chk("R8 pointer at 128", sq, ref_mem[128]);
        // R5 pending cleared: next crossing is sequential
        while (ref_ptr != 8'd255) cyc("R5 read high", 1'b1, 1'b0, 1'b0, 8'd0);
        cyc("R5 sequential after clear", 1'b1, 1'b0, 1'b0, 8'd0);

        // R10 priority of full load
        new_row();
        cyc("R10 split pending", 1'b0, 1'b0, 1'b1, 8'd9);
        new_row();
        cyc("R10 full beats split and step", 1'b1, 1'b1, 1'b1, 8'd127);
        chk("R10 no error on full", {15'd0, terr}, 16'd0);
        cyc("R10 crossing sequential", 1'b1, 1'b0, 1'b0, 8'd0);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic s, f, sp;
            logic [7:0] t;
            s  = ($urandom_range(99) < 65);
            f  = ($urandom_range(99) < 2);
            sp = ($urandom_range(99) < 6);
            t  = ($urandom_range(9) == 0) ? {1'($urandom), 7'd127} : 8'($urandom);
            oe_n = ($urandom_range(9) == 0);
            if (f || sp) new_row();
            cyc("R5 random mix", s, f, sp, t);
        end
        oe_n = 1'b0;
        cyc("R7 enabled", 1'b0, 1'b0, 1'b0, 8'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule